// File: doc/BRIEF.md
# Serial Controller Status Flag Register

This block keeps the status flags of a single-channel serial communications controller and shows them to the CPU as one 8-bit status word. The receiver and transmitter report events to it as one-cycle strobes. These are: a character moved into the receive holding register, a transmit character finished, a parity error, a DLE character match, a framing error and a sync pattern detected. The block latches each event into a sticky flag. Each flag is cleared by its own source: a CPU read of the status or receive-holding register, a CPU load of the transmit-holding register, the receiver being disabled, or a reset-error command.

The two modem-control pins (carrier detect and data set ready, both active low) are brought into the clock domain through a flop synchronizer. Their inverted levels are shown in the two top status bits, and a change on either one raises a sticky change flag. The change flag and the transmit-empty flag share one status bit and one active-low output pin. The receive-ready flag drives its own active-low pin.

The bit that holds framing errors and sync detection clears in a different way in asynchronous and synchronous operation. A mode input selects which rule applies. When a set and a clear reach the same flag in the same cycle, the set takes effect.

Top module: `serial_status_flags`

## Requirements
- R1: Status bit 1 (receive ready) becomes 1 on the clock edge that samples `rx_char_load`. It becomes 0 on an edge that samples `rd_rhr`, or on any edge while `rx_en` is 0. `rx_rdy_n` is the inverse of bit 1.
- R2: Status bit 4 (overrun) becomes 1 when `rx_char_load` is sampled while bit 1 is already 1 and `rd_rhr` is not sampled in the same cycle. It clears on the same conditions as bit 3.
- R3: Status bit 3 becomes 1 when `par_err` or `dle_match` is sampled. It becomes 0 on `reset_err`, or while `rx_en` is 0.
- R4: Status bit 5 becomes 1 when `frame_err` or `sync_det` is sampled, and it becomes 0 while `rx_en` is 0. With `sync_mode`=0, `reset_err` clears it and `rd_status` does not. With `sync_mode`=1, `rd_status` clears it and `reset_err` does not.
- R5: The transmit-empty flag sets when `tx_char_done` is sampled with `tx_hold_pending`=0. It does not set if `tx_hold_pending`=1. Only `wr_thr` clears it; `rd_status` leaves it set.
- R6: Status bit 6 equals the inverse of `dcd_n` and bit 7 equals the inverse of `dsr_n`, each delayed by a two-flop synchronizer. A pin change driven between edges first appears after the second following rising edge.
- R7: The modem-change flag sets on the edge after a synchronized level differs from its previous sample, but only when `tx_en` or `rx_en` is 1. A sampled `rd_status` clears it.
- R8: Status bit 2 is the OR of the transmit-empty and modem-change flags. `txemt_dschg_n` is the inverse of bit 2.
- R9: When a set and a clear reach the same flag in one cycle, the flag ends up set.
- R10: After reset, bits 0 to 5 are 0 and both pins are high. Bit 0 always reads 0. The synchronizer resets to the pin-high state, so bits 6 and 7 read 0 until the pins are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1 selects synchronous clearing rules for bit 5 |
| rx_en | input | 1 | Receiver enable; 0 clears the receive flags |
| tx_en | input | 1 | Transmitter enable |
| rx_char_load | input | 1 | Strobe: character moved into the receive holding register |
| tx_char_done | input | 1 | Strobe: transmit shift register finished a character |
| tx_hold_pending | input | 1 | Transmit holding register has a character waiting |
| par_err | input | 1 | Strobe: parity error on received character |
| dle_match | input | 1 | Strobe: received character matched the DLE value |
| frame_err | input | 1 | Strobe: stop bit missing |
| sync_det | input | 1 | Strobe: sync pattern recognised |
| reset_err | input | 1 | Strobe: reset-error command |
| rd_status | input | 1 | Strobe: CPU reads the status word |
| rd_rhr | input | 1 | Strobe: CPU reads the receive holding register |
| wr_thr | input | 1 | Strobe: CPU loads the transmit holding register |
| dcd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| dsr_n | input | 1 | Data set ready pin, active low, asynchronous |
| status_o | output | 8 | Status word |
| rx_rdy_n | output | 1 | Active-low receive ready |
| txemt_dschg_n | output | 1 | Active-low transmit empty or modem change |

## Verification
The hardest situation to reach is a modem-pin change that must raise bit 2 while the transmit-empty half of that bit is already clear. To reach it, the stimulus first empties the transmit flag with a holding-register load. It then drives a pin between edges and watches bit 2 across exactly three edges. Two more cases are also hard to reach. The first is a clear and a set arriving in the same cycle. The second is a pin change that occurs with both enables low and must never raise the flag. Directed steps place these cases on purpose. A long random phase then mixes all the strobes against a queue-based reference model.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
  localparam int ST_W       = 8;
  localparam int MODEM_N    = 2;
  localparam int B_RXRDY    = 1;
  localparam int B_TXCHG    = 2;
  localparam int B_PARDLE   = 3;
  localparam int B_OVR      = 4;
  localparam int B_FRSYN    = 5;
  localparam int B_DCD      = 6;
  localparam int B_DSR      = 7;

  typedef struct packed {
    logic rx_ready;
    logic tx_empty;
    logic modem_chg;
    logic par_dle;
    logic overrun;
    logic frame_sync;
  } flags_t;

  localparam int NFLAG = $bits(flags_t);

  function automatic logic [ST_W-1:0] pack_status(flags_t f, logic dcd_lvl_n, logic dsr_lvl_n);
    logic [ST_W-1:0] w;
    w           = '0;
    w[B_RXRDY]  = f.rx_ready;
    w[B_TXCHG]  = f.tx_empty | f.modem_chg;
    w[B_PARDLE] = f.par_dle;
    w[B_OVR]    = f.overrun;
    w[B_FRSYN]  = f.frame_sync;
    w[B_DCD]    = ~dcd_lvl_n;
    w[B_DSR]    = ~dsr_lvl_n;
    return w;
  endfunction
endpackage

// File: rtl/ssf_flag.sv
module ssf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/ssf_modem_sync.sv
module ssf_modem_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_n,
  input  logic             enable,
  output logic [LINES-1:0] level_n,
  output logic             change_o
);
  logic [LINES-1:0] prev_n;
  logic [LINES-1:0] diff;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], pin_n[i]};
    end
    assign level_n[i] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_n <= '1;
    else        prev_n <= level_n;
  end

  assign diff     = level_n ^ prev_n;
  assign change_o = enable & (|diff);

  if (STAGES == 2) begin : g_chk
    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          warm <= '0;
      else if (warm != 2'd2) warm <= warm + 2'd1;
    end
    for (genvar i = 0; i < LINES; i++) begin : g_a
      assert_sync_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (level_n[i] == $past(pin_n[i], 2)));
    end
  end
endmodule

// File: rtl/ssf_event_decode.sv
module ssf_event_decode
  import ssf_pkg::*;
(
  input  flags_t flags_q,
  input  logic   sync_mode,
  input  logic   rx_en,
  input  logic   rx_char_load,
  input  logic   tx_char_done,
  input  logic   tx_hold_pending,
  input  logic   par_err,
  input  logic   dle_match,
  input  logic   frame_err,
  input  logic   sync_det,
  input  logic   reset_err,
  input  logic   rd_status,
  input  logic   rd_rhr,
  input  logic   wr_thr,
  input  logic   modem_change,
  output flags_t set_s,
  output flags_t clr_s,
  output logic   overrun_ev,
  output logic   rx_off
);
  logic err_clr;
  logic fs_clr;

  assign rx_off     = ~rx_en;
  assign overrun_ev = rx_char_load & flags_q.rx_ready & ~rd_rhr;
  assign err_clr    = rx_off | reset_err;
  assign fs_clr     = rx_off | (sync_mode ? rd_status : reset_err);

  always_comb begin
    set_s            = '0;
    clr_s            = '0;
    set_s.rx_ready   = rx_char_load;
    clr_s.rx_ready   = rd_rhr | rx_off;
    set_s.overrun    = overrun_ev;
    clr_s.overrun    = err_clr;
    set_s.par_dle    = par_err | dle_match;
    clr_s.par_dle    = err_clr;
    set_s.frame_sync = frame_err | sync_det;
    clr_s.frame_sync = fs_clr;
    set_s.tx_empty   = tx_char_done & ~tx_hold_pending;
    clr_s.tx_empty   = wr_thr;
    set_s.modem_chg  = modem_change;
    clr_s.modem_chg  = rd_status;
  end
endmodule

// File: rtl/serial_status_flags.sv
module serial_status_flags
  import ssf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_mode,
  input  logic            rx_en,
  input  logic            tx_en,
  input  logic            rx_char_load,
  input  logic            tx_char_done,
  input  logic            tx_hold_pending,
  input  logic            par_err,
  input  logic            dle_match,
  input  logic            frame_err,
  input  logic            sync_det,
  input  logic            reset_err,
  input  logic            rd_status,
  input  logic            rd_rhr,
  input  logic            wr_thr,
  input  logic            dcd_n,
  input  logic            dsr_n,
  output logic [ST_W-1:0] status_o,
  output logic            rx_rdy_n,
  output logic            txemt_dschg_n
);
  flags_t             flags_q, set_s, clr_s;
  logic [NFLAG-1:0]   flags_v, set_v, clr_v;
  logic [MODEM_N-1:0] modem_lvl_n;
  logic               modem_change;
  logic               overrun_ev;
  logic               rx_off;

  ssf_modem_sync #(.STAGES(SYNC_STAGES), .LINES(MODEM_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_n    ({dsr_n, dcd_n}),
    .enable   (tx_en | rx_en),
    .level_n  (modem_lvl_n),
    .change_o (modem_change)
  );

  ssf_event_decode u_dec (
    .flags_q        (flags_q),
    .sync_mode      (sync_mode),
    .rx_en          (rx_en),
    .rx_char_load   (rx_char_load),
    .tx_char_done   (tx_char_done),
    .tx_hold_pending(tx_hold_pending),
    .par_err        (par_err),
    .dle_match      (dle_match),
    .frame_err      (frame_err),
    .sync_det       (sync_det),
    .reset_err      (reset_err),
    .rd_status      (rd_status),
    .rd_rhr         (rd_rhr),
    .wr_thr         (wr_thr),
    .modem_change   (modem_change),
    .set_s          (set_s),
    .clr_s          (clr_s),
    .overrun_ev     (overrun_ev),
    .rx_off         (rx_off)
  );

  assign set_v   = set_s;
  assign clr_v   = clr_s;
  assign flags_q = flags_v;

  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    ssf_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v[k]),
      .clr_i (clr_v[k]),
      .q_o   (flags_v[k])
    );
  end

  assign status_o      = pack_status(flags_q, modem_lvl_n[0], modem_lvl_n[1]);
  assign rx_rdy_n      = ~status_o[B_RXRDY];
  assign txemt_dschg_n = ~status_o[B_TXCHG];

  assert_rxrdy_pin_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_char_load |=> !rx_rdy_n);
  assert_rx_disable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_off && !rx_char_load) |=> !status_o[B_RXRDY]);
  assert_overrun_R2: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_ev |=> status_o[B_OVR]);
  assert_err_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_err && !par_err && !dle_match && !rx_char_load)
      |=> (!status_o[B_PARDLE] && !status_o[B_OVR]));
  assert_sync_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && rd_status && !frame_err && !sync_det) |=> !status_o[B_FRSYN]);
  assert_async_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && rd_status && rx_en && !reset_err && status_o[B_FRSYN])
      |=> status_o[B_FRSYN]);
  assert_tx_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.tx_empty && !wr_thr) |=> flags_q.tx_empty);
  assert_modem_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !rx_en && !flags_q.modem_chg) |=> !flags_q.modem_chg);
  assert_txpin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_s.tx_empty || set_s.modem_chg) |=> !txemt_dschg_n);
endmodule

// File: tb/serial_status_flags_tb.sv
module serial_status_flags_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic sync_mode = 0, rx_en = 1, tx_en = 1;
  logic rx_char_load = 0, tx_char_done = 0, tx_hold_pending = 0;
  logic par_err = 0, dle_match = 0, frame_err = 0, sync_det = 0;
  logic reset_err = 0, rd_status = 0, rd_rhr = 0, wr_thr = 0;
  logic dcd_n = 1, dsr_n = 1;
  logic [7:0] status_o;
  logic rx_rdy_n, txemt_dschg_n;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_status_flags u_dut (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .rx_en(rx_en), .tx_en(tx_en),
    .rx_char_load(rx_char_load), .tx_char_done(tx_char_done),
    .tx_hold_pending(tx_hold_pending), .par_err(par_err), .dle_match(dle_match),
    .frame_err(frame_err), .sync_det(sync_det), .reset_err(reset_err),
    .rd_status(rd_status), .rd_rhr(rd_rhr), .wr_thr(wr_thr),
    .dcd_n(dcd_n), .dsr_n(dsr_n), .status_o(status_o), .rx_rdy_n(rx_rdy_n),
    .txemt_dschg_n(txemt_dschg_n)
  );

  // Reference model: one bit per flag, pin history in queues [prev, visible, first stage]
  bit m_rdy, m_ovr, m_par, m_fs, m_txe, m_mc;
  bit dq[$], sq[$];

  always @(posedge clk) begin
    bit n_rdy, n_ovr, n_par, n_fs, n_txe, n_mc, chg;
    if (!rst_n) begin
      m_rdy = 0; m_ovr = 0; m_par = 0; m_fs = 0; m_txe = 0; m_mc = 0;
      dq = '{1, 1, 1}; sq = '{1, 1, 1};
    end else begin
      chg   = (tx_en || rx_en) && ((dq[1] != dq[0]) || (sq[1] != sq[0]));
      n_rdy = rx_char_load ? 1 : ((rd_rhr || !rx_en) ? 0 : m_rdy);
      n_ovr = (rx_char_load && m_rdy && !rd_rhr) ? 1 : ((!rx_en || reset_err) ? 0 : m_ovr);
      n_par = (par_err || dle_match) ? 1 : ((!rx_en || reset_err) ? 0 : m_par);
      n_fs  = (frame_err || sync_det) ? 1 :
              ((!rx_en || (sync_mode ? rd_status : reset_err)) ? 0 : m_fs);
      n_txe = (tx_char_done && !tx_hold_pending) ? 1 : (wr_thr ? 0 : m_txe);
      n_mc  = chg ? 1 : (rd_status ? 0 : m_mc);
      m_rdy = n_rdy; m_ovr = n_ovr; m_par = n_par; m_fs = n_fs; m_txe = n_txe; m_mc = n_mc;
      void'(dq.pop_front()); dq.push_back(dcd_n);
      void'(sq.pop_front()); sq.push_back(dsr_n);
    end
  end

  function automatic string bit_tag(int b);
    case (b)
      0: return "R10"; 1: return "R1"; 2: return "R8"; 3: return "R3";
      4: return "R2";  5: return "R4"; default: return "R6";
    endcase
  endfunction

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && dq.size() == 3) begin
      logic [7:0] exp_w;
      exp_w = {!sq[1], !dq[1], m_fs, m_ovr, m_par, m_txe | m_mc, m_rdy, 1'b0};
      for (int b = 0; b < 8; b++) begin
        n_tests++;
        if (status_o[b] !== exp_w[b]) begin
          n_fail++;
          $display("FAIL %s status bit %0d actual %0b expected %0b at %0t",
                   bit_tag(b), b, status_o[b], exp_w[b], $time);
        end
      end
      n_tests += 2;
      if (rx_rdy_n !== !m_rdy) begin
        n_fail++;
        $display("FAIL R1 rx_rdy_n actual %0b expected %0b", rx_rdy_n, !m_rdy);
      end
      if (txemt_dschg_n !== !(m_txe | m_mc)) begin
        n_fail++;
        $display("FAIL R8 txemt_dschg_n actual %0b expected %0b", txemt_dschg_n, !(m_txe | m_mc));
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp_v);
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp_v);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    rx_char_load = 0; tx_char_done = 0; par_err = 0; dle_match = 0;
    frame_err = 0; sync_det = 0; reset_err = 0; rd_status = 0; rd_rhr = 0; wr_thr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset word", status_o, 8'h00);
    chk("R10 reset pins", {6'd0, rx_rdy_n, txemt_dschg_n}, 8'h03);

    rx_char_load = 1; tick();
    chk("R1 ready set", {status_o[1], rx_rdy_n}, 2'b10);
    rx_char_load = 1; rd_rhr = 1; tick();
    chk("R9 ready set wins over read", status_o[1], 1);
    chk("R2 no overrun when read same cycle", status_o[4], 0);
    rx_char_load = 1; tick();
    chk("R2 overrun set", status_o[4], 1);
    rd_rhr = 1; tick();
    chk("R1 ready cleared by read", {status_o[1], status_o[4]}, 2'b01);
    par_err = 1; tick();
    chk("R3 parity set", status_o[3], 1);
    reset_err = 1; tick();
    chk("R3 reset-error clears", {status_o[3], status_o[4]}, 2'b00);

    frame_err = 1; tick();
    rd_status = 1; tick();
    chk("R4 async read keeps bit5", status_o[5], 1);
    reset_err = 1; tick();
    chk("R4 async reset-error clears", status_o[5], 0);
    sync_mode = 1; sync_det = 1; tick();
    reset_err = 1; tick();
    chk("R4 sync reset-error keeps bit5", status_o[5], 1);
    rd_status = 1; tick();
    chk("R4 sync read clears", status_o[5], 0);
    sync_mode = 0;

    rx_char_load = 1; tick();
    rx_en = 0; tick();
    chk("R1 receiver disable clears", status_o[1], 0);
    rx_en = 1;

    tx_char_done = 1; tx_hold_pending = 1; tick();
    chk("R5 no empty while pending", status_o[2], 0);
    tx_hold_pending = 0; tx_char_done = 1; tick();
    chk("R8 empty pin low", {status_o[2], txemt_dschg_n}, 2'b10);
    rd_status = 1; tick();
    chk("R5 status read keeps empty", status_o[2], 1);
    wr_thr = 1; tick();
    chk("R5 load clears empty", status_o[2], 0);

    dcd_n = 0; tick();
    chk("R6 one edge not yet visible", status_o[6], 0);
    tick();
    chk("R6 dcd visible after two edges", {status_o[6], status_o[2]}, 2'b10);
    tick();
    chk("R7 change flagged", status_o[2], 1);
    rd_status = 1; tick();
    chk("R7 status read clears change", status_o[2], 0);

    tx_en = 0; rx_en = 0; dsr_n = 0;
    tick(); tick(); tick(); tick();
    chk("R6 dsr visible", status_o[7], 1);
    chk("R7 no change while disabled", status_o[2], 0);
    tx_en = 1; rx_en = 1; tick();

    tx_char_done = 1; wr_thr = 1; tick();
    chk("R9 empty set wins over load", status_o[2], 1);
    wr_thr = 1; tick();

    for (int i = 0; i < 4000; i++) begin
      rx_char_load    = ($urandom_range(0, 3) == 0);
      rd_rhr          = ($urandom_range(0, 3) == 0);
      tx_char_done    = ($urandom_range(0, 4) == 0);
      tx_hold_pending = $urandom_range(0, 1);
      wr_thr          = ($urandom_range(0, 4) == 0);
      par_err         = ($urandom_range(0, 9) == 0);
      dle_match       = ($urandom_range(0, 9) == 0);
      frame_err       = ($urandom_range(0, 9) == 0);
      sync_det        = ($urandom_range(0, 9) == 0);
      reset_err       = ($urandom_range(0, 7) == 0);
      rd_status       = ($urandom_range(0, 5) == 0);
      rx_en           = ($urandom_range(0, 19) != 0);
      tx_en           = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 99) == 0) sync_mode = ~sync_mode;
      if ($urandom_range(0, 11) == 0) dcd_n = ~dcd_n;
      if ($urandom_range(0, 11) == 0) dsr_n = ~dsr_n;
      tick();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule